// File: doc/BRIEF.md
# Legacy Peripheral Configuration Port Pair

This block is a byte-wide register file that firmware reaches through two adjacent I/O addresses. A write to the lower address (the index port) selects one of 256 registers. The upper address (the data port) then reads or writes the selected register. A few of these registers are decoded into live control outputs for a parallel port, a floppy controller and a parameterised number of serial ports. Each peripheral gets one enable signal and one relocatable 10-bit I/O base.

The pair responds only while the host bridge drives `bridge_en` high. When `bridge_en` is low, reads return zero and writes change nothing. Each base register stores the peripheral base divided by four. The parallel port is switched off by one specific two-bit code and not by a plain enable bit. A write through the data port to a register with no decoded meaning is still stored. It also raises a one-cycle flag, so a monitor can log the access. The peripherals themselves are outside this block.

Top module: `sio_cfg_top`

## Requirements
- R1: While `rst_n` is low every register clears. Then the following values load: device-enable register (index 0xE2) = 0x0F, floppy base (0xE3) = 0xFC, parallel base (0xE6) = 0xDE, serial 0 base (0xE7) = 0xFE, serial 1 base (0xE8) = 0xBE, identification register (0xE0) = 0x3C, and the index = 0. After reset the outputs are therefore: `par_en`=0, `ser_en`=2'b11, `fdc_en`=0, `fdc_base`=0x3F0, `par_base`=0x378, serial bases 0x3F8 and 0x2F8.
- R2: A write to address `IO_BASE` (default 0x3F0) loads the index. A read of that address returns the current index in the same cycle.
- R3: A data-port access (address `IO_BASE`+1) reads or writes the register that the index selects. A read returns its value combinationally. A write takes effect at the next rising clock edge. Register 0 is the index itself, so a data-port write while the index is 0 loads a new index.
- R4: The device-enable register decodes as follows. `par_en` is high unless bits 1:0 are both 1. `ser_en[i]` is bit i+2. `fdc_en` is bit 4.
- R5: Each base output equals its register value shifted left by two, with the two low bits zero. Serial port i takes its base from index 0xE7+i.
- R6: While `bridge_en` is low, `io_rdata` is zero and writes to either port change no register.
- R7: A data-port write to an index with no decoded meaning is stored and reads back. It changes no output other than `unimp_pulse`. `unimp_pulse` is high for exactly the one cycle after the write edge.
- R8: The identification register (index 0xE0) always reads 0x3C. Data-port writes to it are dropped and do not raise `unimp_pulse`.
- R9: Accesses to addresses outside the pair have no effect, and `io_rdata` stays zero for them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_en | input | 1 | Decode enable for the port pair, from the host bridge |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not selected |
| par_en | output | 1 | Parallel port enable |
| ser_en | output | NUM_SER | Serial port enables |
| fdc_en | output | 1 | Floppy controller enable |
| par_base | output | 10 | Parallel port I/O base |
| fdc_base | output | 10 | Floppy controller I/O base |
| ser_base | output | NUM_SER*10 | Serial port I/O bases, port i at bits i*10 upward |
| unimp_pulse | output | 1 | One-cycle flag after a write to an undecoded index |

## Verification
The assertions check the following on every cycle:
- a blocked or foreign access returns zero read data,
- the gate keeps the index and the bases frozen while the bridge is off,
- the enable decode and each base follow the byte last written to their register,
- the identification byte never moves,
- the flag only follows a data-port write.

Only the bench scenarios show the following:
- the exact reset image,
- reading back values stored at undecoded indices,
- the index being reloaded through register 0,
- the parallel disable code among other bit patterns,
- a second reset restoring relocated bases.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

   localparam int REG_W = 8;

   // decoded register indices
   localparam logic [7:0] IDX_INDEX = 8'h00;
   localparam logic [7:0] IDX_ID    = 8'hE0;
   localparam logic [7:0] IDX_DEVEN = 8'hE2;
   localparam logic [7:0] IDX_FDC   = 8'hE3;
   localparam logic [7:0] IDX_PAR   = 8'hE6;
   localparam logic [7:0] IDX_SER0  = 8'hE7;

   localparam logic [7:0] ID_VALUE  = 8'h3C;

   // register image loaded by reset
   function automatic logic [7:0] reset_value(input logic [7:0] idx);
      case (idx)
         IDX_ID:        return ID_VALUE;
         IDX_DEVEN:     return 8'h0F;
         IDX_FDC:       return 8'hFC;
         IDX_PAR:       return 8'hDE;
         IDX_SER0:      return 8'hFE;
         IDX_SER0 + 1:  return 8'hBE;
         default:       return 8'h00;
      endcase
   endfunction

   // true when a data-port write to idx has a decoded meaning
   function automatic logic is_decoded(input logic [7:0] idx, input int nser);
      logic ser_hit;
      ser_hit = (32'(idx) >= 32'(IDX_SER0)) && (32'(idx) < 32'(IDX_SER0) + 32'(nser));
      return (idx == IDX_INDEX) || (idx == IDX_ID) || (idx == IDX_DEVEN) ||
             (idx == IDX_FDC) || (idx == IDX_PAR) || ser_hit;
   endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
   parameter int          AW      = 16,
   parameter logic [15:0] IO_BASE = 16'h03F0
) (
   input  logic          bridge_en,
   input  logic [AW-1:0] io_addr,
   input  logic          io_wr,
   input  logic          io_rd,
   output logic          idx_wr,
   output logic          dat_wr,
   output logic          idx_rd,
   output logic          dat_rd
);

   localparam logic [AW-1:0] IDX_ADDR = AW'(IO_BASE);
   localparam logic [AW-1:0] DAT_ADDR = AW'(IO_BASE) + AW'(1);

   initial begin
      assert (AW >= 10) else $fatal(1, "address width too small");
      assert (IO_BASE[0] == 1'b0) else $fatal(1, "port pair must start on an even address");
   end

   logic hit_idx, hit_dat;

   always_comb begin
      hit_idx = bridge_en && (io_addr == IDX_ADDR);
      hit_dat = bridge_en && (io_addr == DAT_ADDR);
      idx_wr  = hit_idx && io_wr;
      dat_wr  = hit_dat && io_wr;
      idx_rd  = hit_idx && io_rd;
      dat_rd  = hit_dat && io_rd;
   end

endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
   import sio_cfg_pkg::*;
#(
   parameter int DW      = 8,
   parameter int NUM_SER = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  idx_wr,
   input  logic                  dat_wr,
   input  logic                  idx_rd,
   input  logic                  dat_rd,
   input  logic [DW-1:0]         wdata,
   output logic [DW-1:0]         rdata,
   output logic [DW-1:0]         index_q,
   output logic [DW-1:0]         deven_q,
   output logic [DW-1:0]         fdc_q,
   output logic [DW-1:0]         par_q,
   output logic [NUM_SER*DW-1:0] ser_q,
   output logic                  unimp_q
);

   localparam int DEPTH = 1 << DW;

   initial begin
      assert (DW == REG_W) else $fatal(1, "register width must be 8");
      assert (NUM_SER >= 1 && NUM_SER <= 2) else $fatal(1, "one or two serial ports");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= reset_value(8'(k));
      end else if (idx_wr) begin
         mem[0] <= wdata;
      end else if (dat_wr && (index_q != IDX_ID)) begin
         mem[index_q] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) unimp_q <= 1'b0;
      else        unimp_q <= dat_wr && !is_decoded(index_q, NUM_SER);
   end

   assign index_q = mem[0];
   assign deven_q = mem[IDX_DEVEN];
   assign fdc_q   = mem[IDX_FDC];
   assign par_q   = mem[IDX_PAR];

   for (genvar i = 0; i < NUM_SER; i++) begin : g_ser
      assign ser_q[i*DW +: DW] = mem[8'(IDX_SER0 + i)];
   end

   always_comb begin
      if (idx_rd)      rdata = mem[0];
      else if (dat_rd) rdata = mem[index_q];
      else             rdata = '0;
   end

   // R2: index port write lands in the index
   p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> index_q == $past(wdata));

   // R8: identification byte never changes
   p_id_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(mem[IDX_ID]));

   // R7: flag only follows a data-port write
   p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      unimp_q |-> $past(dat_wr));

endmodule

// File: rtl/sio_dev_decode.sv
module sio_dev_decode #(
   parameter int DW      = 8,
   parameter int NUM_SER = 2,
   parameter int BASE_W  = 10
) (
   input  logic [DW-1:0]             deven_q,
   input  logic [DW-1:0]             fdc_q,
   input  logic [DW-1:0]             par_q,
   input  logic [NUM_SER*DW-1:0]     ser_q,
   output logic                      par_en,
   output logic                      fdc_en,
   output logic [NUM_SER-1:0]        ser_en,
   output logic [BASE_W-1:0]         par_base,
   output logic [BASE_W-1:0]         fdc_base,
   output logic [NUM_SER*BASE_W-1:0] ser_base
);

   localparam int SHIFT = BASE_W - DW;

   initial begin
      assert (SHIFT == 2) else $fatal(1, "bases are stored divided by four");
   end

   assign par_en   = (deven_q[1:0] != 2'b11);
   assign fdc_en   = deven_q[4];
   assign par_base = {par_q, {SHIFT{1'b0}}};
   assign fdc_base = {fdc_q, {SHIFT{1'b0}}};

   for (genvar i = 0; i < NUM_SER; i++) begin : g_ser
      assign ser_en[i]                   = deven_q[i+2];
      assign ser_base[i*BASE_W +: BASE_W] = {ser_q[i*DW +: DW], {SHIFT{1'b0}}};
   end

endmodule

// File: rtl/sio_cfg_top.sv
module sio_cfg_top
   import sio_cfg_pkg::*;
#(
   parameter int          AW      = 16,
   parameter logic [15:0] IO_BASE = 16'h03F0,
   parameter int          NUM_SER = 2,
   parameter int          BASE_W  = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bridge_en,
   input  logic [AW-1:0]             io_addr,
   input  logic                      io_wr,
   input  logic                      io_rd,
   input  logic [7:0]                io_wdata,
   output logic [7:0]                io_rdata,
   output logic                      par_en,
   output logic [NUM_SER-1:0]        ser_en,
   output logic                      fdc_en,
   output logic [BASE_W-1:0]         par_base,
   output logic [BASE_W-1:0]         fdc_base,
   output logic [NUM_SER*BASE_W-1:0] ser_base,
   output logic                      unimp_pulse
);

   localparam int DW = REG_W;

   logic          idx_wr, dat_wr, idx_rd, dat_rd;
   logic [DW-1:0] index_q, deven_q, fdc_q, par_q;
   logic [NUM_SER*DW-1:0] ser_q;

   sio_port_decode #(.AW(AW), .IO_BASE(IO_BASE)) u_dec (
      .bridge_en (bridge_en),
      .io_addr   (io_addr),
      .io_wr     (io_wr),
      .io_rd     (io_rd),
      .idx_wr    (idx_wr),
      .dat_wr    (dat_wr),
      .idx_rd    (idx_rd),
      .dat_rd    (dat_rd)
   );

   sio_reg_file #(.DW(DW), .NUM_SER(NUM_SER)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_wr  (idx_wr),
      .dat_wr  (dat_wr),
      .idx_rd  (idx_rd),
      .dat_rd  (dat_rd),
      .wdata   (io_wdata),
      .rdata   (io_rdata),
      .index_q (index_q),
      .deven_q (deven_q),
      .fdc_q   (fdc_q),
      .par_q   (par_q),
      .ser_q   (ser_q),
      .unimp_q (unimp_pulse)
   );

   sio_dev_decode #(.DW(DW), .NUM_SER(NUM_SER), .BASE_W(BASE_W)) u_devs (
      .deven_q  (deven_q),
      .fdc_q    (fdc_q),
      .par_q    (par_q),
      .ser_q    (ser_q),
      .par_en   (par_en),
      .fdc_en   (fdc_en),
      .ser_en   (ser_en),
      .par_base (par_base),
      .fdc_base (fdc_base),
      .ser_base (ser_base)
   );

   // R6: a closed gate returns nothing
   p_gate_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bridge_en |-> io_rdata == '0);

   // R6: a closed gate freezes state
   p_gate_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bridge_en |=> $stable(index_q) && $stable(fdc_base) && $stable(par_base));

   // R9: foreign addresses read as zero
   p_foreign_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr != AW'(IO_BASE) && io_addr != AW'(IO_BASE) + AW'(1)) |-> io_rdata == '0);

   // R4: parallel enable follows the written two-bit code
   p_par_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && index_q == IDX_DEVEN) |=> par_en == ($past(io_wdata[1:0]) != 2'b11));

   // R5: floppy base is the written byte times four
   p_fdc_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && index_q == IDX_FDC) |=> fdc_base == {$past(io_wdata), 2'b00});

endmodule

// File: tb/sim_sio_cfg_top.sv
`timescale 1ns/100ps
module sim_sio_cfg_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bridge_en = 1'b1;
   logic [15:0] io_addr = 16'h0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h0;
   logic [7:0]  io_rdata;
   logic        par_en, fdc_en, unimp_pulse;
   logic [1:0]  ser_en;
   logic [9:0]  par_base, fdc_base;
   logic [19:0] ser_base;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   sio_cfg_top u0 (
      .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .io_addr(io_addr),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .par_en(par_en), .ser_en(ser_en), .fdc_en(fdc_en), .par_base(par_base),
      .fdc_base(fdc_base), .ser_base(ser_base), .unimp_pulse(unimp_pulse)
   );

   // {is_read, address, data or expected, requirement}
   localparam logic [28:0] VECS [0:14] = '{
      {1'b0, 16'h03F0, 8'hE6, 4'd2},
      {1'b0, 16'h03F1, 8'h9E, 4'd3},
      {1'b1, 16'h03F1, 8'h9E, 4'd3},
      {1'b1, 16'h03F0, 8'hE6, 4'd2},
      {1'b0, 16'h03F0, 8'h55, 4'd2},
      {1'b0, 16'h03F1, 8'hA5, 4'd7},
      {1'b1, 16'h03F1, 8'hA5, 4'd7},
      {1'b0, 16'h03F0, 8'h00, 4'd2},
      {1'b0, 16'h03F1, 8'hE3, 4'd3},
      {1'b1, 16'h03F0, 8'hE3, 4'd3},
      {1'b1, 16'h03F1, 8'hFC, 4'd3},
      {1'b0, 16'h03F0, 8'hE0, 4'd2},
      {1'b0, 16'h03F1, 8'h12, 4'd8},
      {1'b1, 16'h03F1, 8'h3C, 4'd8},
      {1'b1, 16'h03F2, 8'h00, 4'd9}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic check_reset_image(input string tag);
      logic [7:0] v;
      chk({tag, " par_en"},   32'(par_en),   32'h0);
      chk({tag, " ser_en"},   32'(ser_en),   32'h3);
      chk({tag, " fdc_en"},   32'(fdc_en),   32'h0);
      chk({tag, " fdc_base"}, 32'(fdc_base), 32'h3F0);
      chk({tag, " par_base"}, 32'(par_base), 32'h378);
      chk({tag, " ser0"},     32'(ser_base[9:0]),   32'h3F8);
      chk({tag, " ser1"},     32'(ser_base[19:10]), 32'h2F8);
      io_read(16'h03F0, v);
      chk({tag, " index"}, 32'(v), 32'h0);
   endtask

   initial begin
      logic [7:0] v;
      do_reset();
      check_reset_image("R1");
      io_write(16'h03F0, 8'hE0);
      io_read(16'h03F1, v);
      chk("R1 id byte", 32'(v), 32'h3C);

      // table walk: R2 R3 R7 R8 R9
      for (int i = 0; i < 15; i++) begin
         if (VECS[i][28]) begin
            io_read(VECS[i][27:12], v);
            chk($sformatf("R%0d vec%0d", VECS[i][3:0], i), 32'(v), 32'(VECS[i][11:4]));
         end else begin
            io_write(VECS[i][27:12], VECS[i][11:4]);
         end
      end
      chk("R5 par_base relocated", 32'(par_base), 32'h278);

      // R4 enable patterns
      io_write(16'h03F0, 8'hE2);
      io_write(16'h03F1, 8'h11);
      chk("R4 par_en 0x11", 32'(par_en), 32'h1);
      chk("R4 ser_en 0x11", 32'(ser_en), 32'h0);
      chk("R4 fdc_en 0x11", 32'(fdc_en), 32'h1);
      io_write(16'h03F1, 8'h0C);
      chk("R4 par_en 0x0C", 32'(par_en), 32'h1);
      chk("R4 ser_en 0x0C", 32'(ser_en), 32'h3);
      chk("R4 fdc_en 0x0C", 32'(fdc_en), 32'h0);
      io_write(16'h03F1, 8'h07);
      chk("R4 par_en 0x07", 32'(par_en), 32'h0);
      chk("R4 ser_en 0x07", 32'(ser_en), 32'h1);
      io_write(16'h03F1, 8'h02);
      chk("R4 par_en 0x02", 32'(par_en), 32'h1);

      // R5 floppy and serial 1 bases
      io_write(16'h03F0, 8'hE3);
      io_write(16'h03F1, 8'h5D);
      chk("R5 fdc_base", 32'(fdc_base), 32'h174);
      io_write(16'h03F0, 8'hE8);
      io_write(16'h03F1, 8'hFA);
      chk("R5 ser1 base", 32'(ser_base[19:10]), 32'h3E8);

      // R7 undecoded write flags once and moves no output
      io_write(16'h03F0, 8'h77);
      io_write(16'h03F1, 8'h3B);
      chk("R7 pulse high", 32'(unimp_pulse), 32'h1);
      chk("R7 ser0 untouched", 32'(ser_base[9:0]), 32'h3F8);
      chk("R7 fdc untouched", 32'(fdc_base), 32'h174);
      @(negedge clk);
      chk("R7 pulse one cycle", 32'(unimp_pulse), 32'h0);
      io_read(16'h03F1, v);
      chk("R7 stored", 32'(v), 32'h3B);

      // R8 id write raises no flag
      io_write(16'h03F0, 8'hE0);
      io_write(16'h03F1, 8'h99);
      chk("R8 no pulse", 32'(unimp_pulse), 32'h0);

      // R6 closed gate
      io_write(16'h03F0, 8'hE7);
      bridge_en = 1'b0;
      io_write(16'h03F0, 8'hE8);
      io_write(16'h03F1, 8'h00);
      io_read(16'h03F0, v);
      chk("R6 read blocked", 32'(v), 32'h0);
      bridge_en = 1'b1;
      io_read(16'h03F0, v);
      chk("R6 index kept", 32'(v), 32'hE7);
      chk("R6 ser0 kept", 32'(ser_base[9:0]), 32'h3F8);

      // R9 foreign address write has no effect
      io_write(16'h03F2, 8'h10);
      io_read(16'h03F0, v);
      chk("R9 index kept", 32'(v), 32'hE7);

      // second reset restores the image (R1)
      do_reset();
      check_reset_image("R1 again");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule